// File: doc/BRIEF.md
# Flash Program-Check Command Sequencer

This block is the engine in a flash controller that checks whether one 32-bit word was programmed firmly. Software loads a small bank of byte-wide command registers with an opcode, a 24-bit byte address, a margin-choice byte and four expected data bytes. It then launches the command by clearing the command-complete flag. The engine validates the command. If the command is accepted, it reads the addressed word twice through the flash-array read port. The first read uses the margin-1 level and the second uses the margin-0 level. Each read is compared against the expected bytes.

Any mismatch sets a single margin-failure flag. A command that is refused sets the access-error flag and finishes without touching the read port. The flash array itself sits outside this block. Only its read port is seen here: a request pulse, an address, a margin-level code, and a valid strobe that comes back with the data some cycles later.

Top module: `pgm_check_engine`

## Requirements
- R1: After reset, `done_flag` is 1, `acc_err` is 0, `margin_fail` is 0 and `rd_req` is 0.
- R2: A `launch` pulse while `done_flag` is 1 clears `done_flag`, `acc_err` and `margin_fail` at the next clock edge. `done_flag` stays 1 until such a launch. A `launch` while `done_flag` is 0 has no effect.
- R3: Command register writes (index 0 opcode, 1..3 address bits [23:16],[15:8],[7:0], 4 margin choice, 8..11 expected bytes 0..3) are ignored while `done_flag` is 0.
- R4: A command is refused, with `acc_err` set to 1 and `done_flag` set one cycle after the launch edge and no read request issued, when any of these holds: the opcode is not 0x02, address bits [1:0] are not 00, the margin choice is neither 0x01 nor 0x02, the address is at or above `FLASH_BYTES`, or `cmd_allowed` is 0.
- R5: An accepted command issues exactly two read requests to the command address. The first uses the margin-1 level. The second is issued only after the first `rd_valid` and uses the margin-0 level.
- R6: `rd_margin` is coded {level, side}. Level is 0 for user and 1 for factory. Side is 0 for margin-1 and 1 for margin-0. Margin choice 0x01 gives codes 00 then 01, and choice 0x02 gives codes 10 then 11.
- R7: Lane k of `rd_data` (bits 8k+7:8k, the byte at start+k) is compared with expected byte 3-k. Expected byte 3 therefore belongs to the start address and expected byte 0 to start+3.
- R8: `margin_fail` is 1 after a command if either read mismatched, whether at margin-1 only, at margin-0 only or at both. It is 0 if both reads matched.
- R9: `done_flag` rises at the clock edge right after the edge that samples the second `rd_valid`.
- R10: `rd_req` is a one-cycle pulse. `rd_addr` stays unchanged while a command is in progress.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| cmd_wr_en | input | 1 | Command register write strobe |
| cmd_wr_idx | input | 4 | Command register index |
| cmd_wr_data | input | 8 | Command register write data |
| launch | input | 1 | Clear-complete pulse that starts a command |
| cmd_allowed | input | 1 | Mode/security permits the command |
| rd_valid | input | 1 | Read data valid from the array port |
| rd_data | input | 32 | Read data, lane k = byte at address+k |
| done_flag | output | 1 | Command complete |
| acc_err | output | 1 | Access error |
| margin_fail | output | 1 | Margin check failed |
| rd_req | output | 1 | Read request pulse |
| rd_addr | output | 24 | Read byte address |
| rd_margin | output | 2 | Margin code {level, side} |

## Verification
The compare path is tried with read data that matches at both margins, with a single flipped bit at margin-1 only, at margin-0 only, and with the expected bytes mirrored into the opposite lanes. Passing and failing at each margin alone shows that both reads feed the one flag. The mirrored pattern tells a correct reverse byte mapping apart from a straight one. Each refusal reason is tried alone, including the addresses on either side of the flash size limit, to show that no read is issued. A command rewritten and relaunched in mid-flight shows that the register bank is locked while a command runs.

// File: rtl/pchk_pkg.sv
package pchk_pkg;

  localparam int CMD_BYTES  = 12;
  localparam int IDX_OPC    = 0;
  localparam int IDX_ADDR2  = 1;
  localparam int IDX_ADDR1  = 2;
  localparam int IDX_ADDR0  = 3;
  localparam int IDX_MSEL   = 4;
  localparam int IDX_EXP0   = 8;
  localparam int EXP_BYTES  = 4;

  localparam logic [7:0] MSEL_USER    = 8'h01;
  localparam logic [7:0] MSEL_FACTORY = 8'h02;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_CHECK = 2'd1,
    ST_RD1   = 2'd2,
    ST_RD0   = 2'd3
  } pchk_state_e;

  typedef struct packed {
    logic no_perm;
    logic bad_opc;
    logic bad_align;
    logic bad_msel;
    logic bad_range;
  } pchk_err_t;

endpackage

// File: rtl/pchk_cmd_bank.sv
module pchk_cmd_bank #(
  parameter int NBYTES = 12,
  localparam int IDX_W = $clog2(NBYTES)
) (
  input  logic                   clk,
  input  logic                   rst,
  input  logic                   wr_en,
  input  logic [IDX_W-1:0]       wr_idx,
  input  logic [7:0]             wr_data,
  input  logic                   lock,
  output logic [NBYTES-1:0][7:0] regs
);

  for (genvar g = 0; g < NBYTES; g++) begin : g_byte
    always_ff @(posedge clk) begin
      if (rst) begin
        regs[g] <= 8'h00;
      end else if (wr_en && !lock && (wr_idx == IDX_W'(g))) begin
        regs[g] <= wr_data;
      end
    end
  end

endmodule

// File: rtl/pchk_decode.sv
module pchk_decode
  import pchk_pkg::*;
#(
  parameter int          ADDR_W      = 24,
  parameter int unsigned FLASH_BYTES = 32'h0004_0000,
  parameter logic [7:0]  OPC_CHECK   = 8'h02,
  localparam int DATA_W     = 8 * EXP_BYTES,
  localparam int ALIGN_BITS = $clog2(EXP_BYTES)
) (
  input  logic [CMD_BYTES-1:0][7:0] regs,
  input  logic                      allowed,
  output logic [ADDR_W-1:0]         addr,
  output logic                      is_factory,
  output logic [DATA_W-1:0]         expect_word,
  output pchk_err_t                 err,
  output logic                      any_err
);

  assign addr = {regs[IDX_ADDR2], regs[IDX_ADDR1], regs[IDX_ADDR0]};
  assign is_factory = (regs[IDX_MSEL] == MSEL_FACTORY);

  // lane k holds the byte at start+k, which maps to expected byte 3-k
  for (genvar k = 0; k < EXP_BYTES; k++) begin : g_lane
    assign expect_word[8*k +: 8] = regs[IDX_EXP0 + EXP_BYTES - 1 - k];
  end

  always_comb begin
    err.no_perm   = !allowed;
    err.bad_opc   = (regs[IDX_OPC] != OPC_CHECK);
    err.bad_align = (addr[ALIGN_BITS-1:0] != '0);
    err.bad_msel  = (regs[IDX_MSEL] != MSEL_USER) && (regs[IDX_MSEL] != MSEL_FACTORY);
    err.bad_range = ({{(32-ADDR_W){1'b0}}, addr} >= FLASH_BYTES);
  end

  assign any_err = |err;

endmodule

// File: rtl/pchk_compare.sv
module pchk_compare #(
  parameter int LANES = 4,
  localparam int DATA_W = 8 * LANES
) (
  input  logic [DATA_W-1:0] got,
  input  logic [DATA_W-1:0] want,
  output logic [LANES-1:0]  lane_bad,
  output logic              mismatch
);

  for (genvar k = 0; k < LANES; k++) begin : g_cmp
    assign lane_bad[k] = (got[8*k +: 8] != want[8*k +: 8]);
  end

  assign mismatch = |lane_bad;

endmodule

// File: rtl/pchk_seq.sv
module pchk_seq
  import pchk_pkg::*;
#(
  parameter int ADDR_W = 24,
  localparam int DATA_W = 8 * EXP_BYTES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              start,
  input  logic [ADDR_W-1:0] cmd_addr,
  input  logic              cmd_factory,
  input  logic [DATA_W-1:0] cmd_expect,
  input  logic              cmd_err,
  input  logic              rd_valid,
  input  logic              mismatch,
  output logic [DATA_W-1:0] exp_q,
  output logic              done,
  output logic              acc_err,
  output logic              fail,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [1:0]        rd_margin,
  output pchk_state_e       state
);

  logic fac_q;

  always_ff @(posedge clk) begin
    if (rst) begin
      state     <= ST_IDLE;
      done      <= 1'b1;
      acc_err   <= 1'b0;
      fail      <= 1'b0;
      rd_req    <= 1'b0;
      rd_addr   <= '0;
      rd_margin <= 2'b00;
      fac_q     <= 1'b0;
      exp_q     <= '0;
    end else begin
      rd_req <= 1'b0;
      unique case (state)
        ST_IDLE: begin
          if (start) begin
            done    <= 1'b0;
            acc_err <= 1'b0;
            fail    <= 1'b0;
            rd_addr <= cmd_addr;
            fac_q   <= cmd_factory;
            exp_q   <= cmd_expect;
            state   <= ST_CHECK;
          end
        end
        ST_CHECK: begin
          if (cmd_err) begin
            acc_err <= 1'b1;
            done    <= 1'b1;
            state   <= ST_IDLE;
          end else begin
            rd_req    <= 1'b1;
            rd_margin <= {fac_q, 1'b0};
            state     <= ST_RD1;
          end
        end
        ST_RD1: begin
          if (rd_valid) begin
            if (mismatch) fail <= 1'b1;
            rd_req    <= 1'b1;
            rd_margin <= {fac_q, 1'b1};
            state     <= ST_RD0;
          end
        end
        ST_RD0: begin
          if (rd_valid) begin
            if (mismatch) fail <= 1'b1;
            done  <= 1'b1;
            state <= ST_IDLE;
          end
        end
        default: state <= ST_IDLE;
      endcase
    end
  end

endmodule

// File: rtl/pgm_check_engine.sv
module pgm_check_engine
  import pchk_pkg::*;
#(
  parameter int          ADDR_W      = 24,
  parameter int unsigned FLASH_BYTES = 32'h0004_0000,
  parameter logic [7:0]  OPC_CHECK   = 8'h02,
  localparam int IDX_W  = $clog2(CMD_BYTES),
  localparam int DATA_W = 8 * EXP_BYTES
) (
  input  logic              clk,
  input  logic              rst,
  input  logic              cmd_wr_en,
  input  logic [IDX_W-1:0]  cmd_wr_idx,
  input  logic [7:0]        cmd_wr_data,
  input  logic              launch,
  input  logic              cmd_allowed,
  input  logic              rd_valid,
  input  logic [DATA_W-1:0] rd_data,
  output logic              done_flag,
  output logic              acc_err,
  output logic              margin_fail,
  output logic              rd_req,
  output logic [ADDR_W-1:0] rd_addr,
  output logic [1:0]        rd_margin
);

  logic [CMD_BYTES-1:0][7:0] cmd_regs;
  logic                      launch_go;
  logic [ADDR_W-1:0]         dec_addr;
  logic                      dec_factory;
  logic [DATA_W-1:0]         dec_expect;
  pchk_err_t                 dec_err;
  logic                      dec_any_err;
  logic [DATA_W-1:0]         exp_q;
  logic [EXP_BYTES-1:0]      lane_bad;
  logic                      cmp_mismatch;
  pchk_state_e               seq_state;

  assign launch_go = launch && done_flag;

  pchk_cmd_bank #(.NBYTES(CMD_BYTES)) u_bank (
    .clk     (clk),
    .rst     (rst),
    .wr_en   (cmd_wr_en),
    .wr_idx  (cmd_wr_idx),
    .wr_data (cmd_wr_data),
    .lock    (!done_flag || launch_go),
    .regs    (cmd_regs)
  );

  pchk_decode #(
    .ADDR_W      (ADDR_W),
    .FLASH_BYTES (FLASH_BYTES),
    .OPC_CHECK   (OPC_CHECK)
  ) u_dec (
    .regs        (cmd_regs),
    .allowed     (cmd_allowed),
    .addr        (dec_addr),
    .is_factory  (dec_factory),
    .expect_word (dec_expect),
    .err         (dec_err),
    .any_err     (dec_any_err)
  );

  pchk_compare #(.LANES(EXP_BYTES)) u_cmp (
    .got      (rd_data),
    .want     (exp_q),
    .lane_bad (lane_bad),
    .mismatch (cmp_mismatch)
  );

  pchk_seq #(.ADDR_W(ADDR_W)) u_seq (
    .clk         (clk),
    .rst         (rst),
    .start       (launch_go),
    .cmd_addr    (dec_addr),
    .cmd_factory (dec_factory),
    .cmd_expect  (dec_expect),
    .cmd_err     (dec_any_err),
    .rd_valid    (rd_valid),
    .mismatch    (cmp_mismatch),
    .exp_q       (exp_q),
    .done        (done_flag),
    .acc_err     (acc_err),
    .fail        (margin_fail),
    .rd_req      (rd_req),
    .rd_addr     (rd_addr),
    .rd_margin   (rd_margin),
    .state       (seq_state)
  );

endmodule

// File: rtl/pchk_sva.sv
module pchk_sva
  import pchk_pkg::*;
#(
  parameter int ADDR_W = 24
) (
  input logic              clk,
  input logic              rst,
  input logic              launch,
  input logic              done_flag,
  input logic              acc_err,
  input logic              margin_fail,
  input logic              rd_req,
  input logic [ADDR_W-1:0] rd_addr,
  input logic [1:0]        rd_margin,
  input logic              rd_valid,
  input logic              dec_factory,
  input pchk_state_e       seq_state
);

  assert_launch_clears_R2: assert property (@(posedge clk) disable iff (rst)
    (launch && done_flag) |=> (!done_flag && !acc_err && !margin_fail));

  assert_done_holds_R2: assert property (@(posedge clk) disable iff (rst)
    (done_flag && !launch) |=> done_flag);

  assert_err_no_read_R4: assert property (@(posedge clk) disable iff (rst)
    acc_err |-> !rd_req);

  assert_req_only_busy_R5: assert property (@(posedge clk) disable iff (rst)
    rd_req |-> !done_flag);

  assert_margin_level_R6: assert property (@(posedge clk) disable iff (rst)
    rd_req |-> (rd_margin[1] == dec_factory));

  assert_final_valid_done_R9: assert property (@(posedge clk) disable iff (rst)
    (rd_valid && seq_state == ST_RD0) |=> done_flag);

  assert_req_pulse_R10: assert property (@(posedge clk) disable iff (rst)
    rd_req |=> !rd_req);

  assert_addr_stable_R10: assert property (@(posedge clk) disable iff (rst)
    !done_flag |=> $stable(rd_addr));

endmodule

bind pgm_check_engine pchk_sva #(.ADDR_W(ADDR_W)) u_sva (
  .clk         (clk),
  .rst         (rst),
  .launch      (launch),
  .done_flag   (done_flag),
  .acc_err     (acc_err),
  .margin_fail (margin_fail),
  .rd_req      (rd_req),
  .rd_addr     (rd_addr),
  .rd_margin   (rd_margin),
  .rd_valid    (rd_valid),
  .dec_factory (dec_factory),
  .seq_state   (seq_state)
);

// File: tb/tb_pgm_check_engine.sv
`timescale 1ns/1ps
module tb_pgm_check_engine;

  localparam int LAT = 4;
  localparam int unsigned FBYTES = 32'h0004_0000;

  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic        cmd_wr_en = 1'b0;
  logic [3:0]  cmd_wr_idx = '0;
  logic [7:0]  cmd_wr_data = '0;
  logic        launch = 1'b0;
  logic        cmd_allowed = 1'b1;
  logic        rd_valid = 1'b0;
  logic [31:0] rd_data = '0;
  logic        done_flag, acc_err, margin_fail, rd_req;
  logic [23:0] rd_addr;
  logic [1:0]  rd_margin;

  int checks = 0;
  int errors = 0;

  always #2.5 clk = ~clk;

  pgm_check_engine dut (
    .clk(clk), .rst(rst), .cmd_wr_en(cmd_wr_en), .cmd_wr_idx(cmd_wr_idx),
    .cmd_wr_data(cmd_wr_data), .launch(launch), .cmd_allowed(cmd_allowed),
    .rd_valid(rd_valid), .rd_data(rd_data), .done_flag(done_flag),
    .acc_err(acc_err), .margin_fail(margin_fail), .rd_req(rd_req),
    .rd_addr(rd_addr), .rd_margin(rd_margin)
  );

  // array read-port model
  logic [31:0] model_word = '0;
  logic [31:0] flip1 = '0;
  logic [31:0] flip0 = '0;
  int          cyc = 0;
  int          vcyc = 0;
  int          cnt = 0;
  int          req_cnt = 0;
  int          viol = 0;
  logic        prev_req = 1'b0;
  logic [1:0]  cap_m = '0;
  logic [23:0] cap_a = '0;
  logic [1:0]  req_m [16];
  logic [23:0] req_a [16];

  always @(posedge clk) begin
    cyc      <= cyc + 1;
    rd_valid <= 1'b0;
    prev_req <= rd_req;
    if (rd_req && prev_req) viol <= viol + 1;
    if (rd_req) begin
      cnt <= LAT;
      cap_m <= rd_margin;
      cap_a <= rd_addr;
      req_m[req_cnt[3:0]] <= rd_margin;
      req_a[req_cnt[3:0]] <= rd_addr;
      req_cnt <= req_cnt + 1;
    end else if (cnt == 1) begin
      if (rd_addr != cap_a) viol <= viol + 1;
      rd_valid <= 1'b1;
      rd_data  <= model_word ^ (cap_m[0] ? flip0 : flip1);
      vcyc     <= cyc + 1;
      cnt      <= 0;
    end else if (cnt > 1) begin
      cnt <= cnt - 1;
    end
  end

  task automatic chk(input bit ok, input string tag, input string what,
                     input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, exp);
    end
  endtask

  task automatic wr(input int idx, input logic [7:0] d);
    @(negedge clk);
    cmd_wr_en = 1'b1; cmd_wr_idx = idx[3:0]; cmd_wr_data = d;
    @(negedge clk);
    cmd_wr_en = 1'b0;
  endtask

  task automatic load(input logic [7:0] opc, input logic [23:0] a, input logic [7:0] ms,
                      input logic [7:0] e0, input logic [7:0] e1,
                      input logic [7:0] e2, input logic [7:0] e3);
    wr(0, opc); wr(1, a[23:16]); wr(2, a[15:8]); wr(3, a[7:0]); wr(4, ms);
    wr(8, e0); wr(9, e1); wr(10, e2); wr(11, e3);
  endtask

  task automatic pulse_launch();
    @(negedge clk); launch = 1'b1;
    @(negedge clk); launch = 1'b0;
  endtask

  // launch, check R2 clearing, wait for completion; returns cycles waited
  task automatic run(output int waited, output int base);
    base = req_cnt;
    pulse_launch();
    chk(!done_flag && !acc_err && !margin_fail, "R2", "flags after launch",
        {done_flag, acc_err, margin_fail}, 3'b000);
    waited = 0;
    while (!done_flag && waited < 200) begin
      @(negedge clk); waited++;
    end
    chk(done_flag, "R2", "command completes", done_flag, 1);
  endtask

  task automatic t_reset();
    chk(done_flag && !acc_err && !margin_fail && !rd_req, "R1", "reset state",
        {done_flag, acc_err, margin_fail, rd_req}, 4'b1000);
  endtask

  task automatic t_pass(input logic [7:0] ms, input logic [23:0] a, input string tag);
    int w, b;
    model_word = 32'h1122_3344; flip1 = '0; flip0 = '0;
    load(8'h02, a, ms, 8'h11, 8'h22, 8'h33, 8'h44);
    run(w, b);
    chk(!acc_err && !margin_fail, "R8", {"both match ", tag}, {acc_err, margin_fail}, 0);
    chk(req_cnt - b == 2, "R5", {"two reads ", tag}, req_cnt - b, 2);
    chk(req_a[b[3:0]] == a && req_a[4'(b+1)] == a, "R5", {"read address ", tag},
        req_a[4'(b+1)], a);
    chk(req_m[b[3:0]] == {ms == 8'h02, 1'b0} && req_m[4'(b+1)] == {ms == 8'h02, 1'b1},
        "R6", {"margin codes ", tag}, {req_m[b[3:0]], req_m[4'(b+1)]},
        {ms == 8'h02, 1'b0, ms == 8'h02, 1'b1});
    chk(cyc == vcyc + 1, "R9", {"done after last valid ", tag}, cyc, vcyc + 1);
  endtask

  task automatic t_fail_one(input bit at_m0);
    int w, b;
    model_word = 32'hA1B2_C3D4;
    flip1 = at_m0 ? 32'h0 : 32'h0000_0100;
    flip0 = at_m0 ? 32'h0100_0000 : 32'h0;
    load(8'h02, 24'h000400, 8'h01, 8'hA1, 8'hB2, 8'hC3, 8'hD4);
    run(w, b);
    chk(margin_fail && !acc_err, "R8", at_m0 ? "mismatch at margin-0 only" : "mismatch at margin-1 only",
        margin_fail, 1);
    chk(req_cnt - b == 2, "R5", "still two reads after mismatch", req_cnt - b, 2);
    flip1 = '0; flip0 = '0;
  endtask

  task automatic t_order();
    int w, b;
    model_word = 32'h4433_2211;  // mirrored lanes
    load(8'h02, 24'h000800, 8'h01, 8'h11, 8'h22, 8'h33, 8'h44);
    run(w, b);
    chk(margin_fail, "R7", "mirrored byte order rejected", margin_fail, 1);
    model_word = 32'h1122_3344;
    run(w, b);
    chk(!margin_fail, "R7", "expected byte 3 at start address", margin_fail, 0);
  endtask

  task automatic t_refuse(input logic [7:0] opc, input logic [23:0] a, input logic [7:0] ms,
                          input bit allow, input string what);
    int w, b;
    model_word = 32'h1122_3344;
    load(opc, a, ms, 8'h11, 8'h22, 8'h33, 8'h44);
    cmd_allowed = allow;
    run(w, b);
    cmd_allowed = 1'b1;
    chk(acc_err && !margin_fail, "R4", what, {acc_err, margin_fail}, 2'b10);
    chk(req_cnt == b, "R4", {what, " no read"}, req_cnt - b, 0);
    chk(w == 1, "R4", {what, " completes next cycle"}, w, 1);
  endtask

  task automatic t_lock();
    int w, b;
    model_word = 32'h1122_3344;
    load(8'h02, 24'h000200, 8'h01, 8'h11, 8'h22, 8'h33, 8'h44);
    b = req_cnt;
    pulse_launch();
    wr(3, 8'h01); wr(4, 8'h03); pulse_launch();
    chk(!done_flag, "R3", "still busy during writes", done_flag, 0);
    w = 0;
    while (!done_flag && w < 200) begin @(negedge clk); w++; end
    chk(!acc_err && !margin_fail && req_cnt - b == 2, "R2", "launch while busy ignored",
        req_cnt - b, 2);
    run(w, b);
    chk(!acc_err && req_a[b[3:0]] == 24'h000200, "R3", "writes while busy ignored",
        req_a[b[3:0]], 24'h000200);
  endtask

  initial begin
    #1ms;
    errors++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

  initial begin
    repeat (3) @(negedge clk);
    rst = 1'b0;
    @(negedge clk);
    t_reset();
    t_pass(8'h01, 24'h000100, "user");
    t_pass(8'h02, 24'h000104, "factory");
    t_fail_one(1'b0);
    t_fail_one(1'b1);
    t_order();
    t_refuse(8'h02, 24'h000102, 8'h01, 1'b1, "misaligned address");
    t_pass(8'h01, 24'h000300, "acc_err cleared by next launch");
    t_refuse(8'h02, 24'h000100, 8'h03, 1'b1, "bad margin choice");
    t_refuse(8'h05, 24'h000100, 8'h01, 1'b1, "bad opcode");
    t_refuse(8'h02, FBYTES[23:0], 8'h01, 1'b1, "address at size limit");
    t_pass(8'h02, FBYTES[23:0] - 24'd4, "last word");
    t_refuse(8'h02, 24'h000100, 8'h01, 1'b0, "not allowed");
    t_lock();
    chk(viol == 0, "R10", "req pulse and address stable", viol, 0);
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end

endmodule